// File: doc/BRIEF.md
# USB Host Attach-Detect Interrupt Register

This block is the interrupt status register of a small USB host port. It samples the D+ and D- lines through a synchronizer, turns each pair of levels into a bus state (SE0, J, K or SE1), and accepts a new bus state only after it has held for a programmable number of clocks. Once accepted, a direct move between SE0 and the idle J state sets a latched attach/detach interrupt. A move from J to K sets a latched resume interrupt while resume mode is selected.

The same status byte also latches three event pulses from neighbouring logic: start-of-frame timer expiry and two transfer-done strobes. It shows the live D+ level, so software can tell a full-speed device from a low-speed one after an attach. Bit 6 has two meanings. In resume mode it is the resume interrupt. Otherwise it is a live flag that reads 1 while no device is attached.

Software reads the byte at any time. It clears interrupt bits by writing ones to their positions. A single interrupt line is raised when any latched bit is set and its enable bit is set.

Top module: `usb_attach_irq`

## Requirements
- R1: After reset every latched bit is 0, `irq` is 0, and with both lines low `rd_data` reads 8'h40 (bit 6 = 1: no device, bit 7 = 0).
- R2: Bits 3 and 2 of `rd_data` always read 0, and writing ones to them has no visible effect.
- R3: A write sets `wr_en` for one cycle with `wr_data`. Each bit written as 1 clears that latched bit (bits 0, 1, 4, 5 and bit 6 in resume mode) on the next edge. Bits written as 0 keep their value.
- R4: If an event and a clear of the same bit land in the same cycle, the bit ends up set.
- R5: An accepted bus change from SE0 to J sets bit 5 (attach). J is D+ high/D- low when `low_speed` is 0, and D- high/D+ low when `low_speed` is 1.
- R6: An accepted bus change from J to SE0 sets bit 5 (detach).
- R7: A new line state counts only after it has stayed unchanged for `debounce_cycles` clocks after synchronization. A shorter glitch produces no transition.
- R8: With `resume_mode` = 0, bit 6 reads 1 while the accepted bus state is SE0 and 0 otherwise.
- R9: With `resume_mode` = 1, an accepted change from J to K latches bit 6. The same change with `resume_mode` = 0 latches nothing.
- R10: Bit 7 follows D+ after a two-flop synchronizer. It reads 1 after a full-speed attach and 0 after a low-speed attach.
- R11: A one-cycle pulse on `done_a_evt`, `done_b_evt` or `sof_evt` sets bit 0, 1 or 4 respectively.
- R12: `irq` is 1 exactly when a latched bit is set and its bit in `irq_en` is set. Bit 7 never drives `irq`. Bit 6 drives it only in resume mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_in | input | 1 | D+ line level, asynchronous |
| dm_in | input | 1 | D- line level, asynchronous |
| low_speed | input | 1 | Selects which line is high in the J state |
| resume_mode | input | 1 | 1: bit 6 is the resume interrupt; 0: bit 6 is the no-device flag |
| debounce_cycles | input | DEB_W | Clocks a line state must hold before it is accepted |
| sof_evt | input | 1 | Start-of-frame timer pulse |
| done_a_evt | input | 1 | Transfer A done pulse |
| done_b_evt | input | 1 | Transfer B done pulse |
| wr_en | input | 1 | Write strobe for clearing bits |
| wr_data | input | 8 | Write-one-to-clear mask |
| irq_en | input | 8 | Interrupt enable mask |
| rd_data | output | 8 | Status byte |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that the event inputs and the write strobe are synchronous to `clk`. They also assume that `resume_mode` does not change in the cycle right after an accepted J-to-K change. The bench drives every synchronous input on the falling edge and holds `resume_mode` steady while line changes settle. It moves the lines only after the previous state has either been accepted or deliberately cut short as a glitch.

// File: rtl/usb_attach_pkg.sv
package usb_attach_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_J   = 2'd1,
    LS_K   = 2'd2,
    LS_SE1 = 2'd3
  } line_st_e;

  localparam int BIT_DONE_A = 0;
  localparam int BIT_DONE_B = 1;
  localparam int BIT_SOF    = 4;
  localparam int BIT_ATTACH = 5;
  localparam int BIT_DETRES = 6;
  localparam int BIT_DPLUS  = 7;

  // positions that hold a latched interrupt
  localparam logic [7:0] LATCH_MASK = 8'b0111_0011;

  // decode the two line levels into a bus state; J polarity depends on speed
  function automatic line_st_e classify(input logic dp, input logic dm,
                                        input logic low_spd);
    line_st_e s;
    if (!dp && !dm)      s = LS_SE0;
    else if (dp && dm)   s = LS_SE1;
    else if (dp ^ low_spd) s = LS_J;
    else                 s = LS_K;
    return s;
  endfunction

  // one latched bit: a set request overrides a clear request
  function automatic logic w1c_bit(input logic cur, input logic set,
                                   input logic clr);
    return set | (cur & ~clr);
  endfunction

  // enables actually in force: bit 6 only counts in resume mode
  function automatic logic [7:0] live_enables(input logic [7:0] en,
                                              input logic mode);
    logic [7:0] e;
    e = en & LATCH_MASK;
    e[BIT_DETRES] = e[BIT_DETRES] & mode;
    return e;
  endfunction

endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/usb_line_debounce.sv
module usb_line_debounce
  import usb_attach_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp,
  input  logic          dm,
  input  logic          low_spd,
  input  logic [CW-1:0] limit,
  output line_st_e      stable_o,
  output logic          commit_o,
  output line_st_e      from_o,
  output line_st_e      to_o
);
  line_st_e      raw;
  line_st_e      cand;
  line_st_e      stable;
  logic [CW-1:0] cnt;
  logic          held;

  assign raw  = classify(dp, dm, low_spd);
  assign held = (raw == cand) && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand   <= LS_SE0;
      stable <= LS_SE0;
      cnt    <= '0;
    end else if (raw != cand) begin
      cand <= raw;
      cnt  <= '0;
    end else if (cnt != limit) begin
      cnt <= cnt + 1'b1;
    end else if (stable != cand) begin
      stable <= cand;
    end
  end

  assign commit_o = held && (stable != cand);
  assign from_o   = stable;
  assign to_o     = cand;
  assign stable_o = stable;
endmodule

// File: rtl/usb_irq_bits.sv
module usb_irq_bits
  import usb_attach_pkg::*;
#(
  parameter int         W    = 8,
  parameter logic [7:0] MASK = LATCH_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] lat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat[i] <= 1'b0;
        else        lat[i] <= w1c_bit(lat[i], set[i], clr[i]);
      end
    end else begin : g_none
      assign lat[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usb_attach_irq.sv
module usb_attach_irq
  import usb_attach_pkg::*;
#(
  parameter int DEB_W     = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_in,
  input  logic             dm_in,
  input  logic             low_speed,
  input  logic             resume_mode,
  input  logic [DEB_W-1:0] debounce_cycles,
  input  logic             sof_evt,
  input  logic             done_a_evt,
  input  logic             done_b_evt,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       irq_en,
  output logic [7:0]       rd_data,
  output logic             irq
);
  logic [1:0] line_sync;
  logic       dp_sync;
  logic       dm_sync;
  line_st_e   line_stable;
  line_st_e   tr_from;
  line_st_e   tr_to;
  logic       tr_commit;

  // named internal events, observed by the checker
  logic       insert_evt;
  logic       remove_evt;
  logic       resume_evt;
  logic [7:0] evt_set;
  logic [7:0] evt_clr;
  logic [7:0] lat;

  usb_line_sync #(.STAGES(SYNC_DEPTH), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({dp_in, dm_in}),
    .q    (line_sync)
  );
  assign dp_sync = line_sync[1];
  assign dm_sync = line_sync[0];

  usb_line_debounce #(.CW(DEB_W)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .dp      (dp_sync),
    .dm      (dm_sync),
    .low_spd (low_speed),
    .limit   (debounce_cycles),
    .stable_o(line_stable),
    .commit_o(tr_commit),
    .from_o  (tr_from),
    .to_o    (tr_to)
  );

  assign insert_evt = tr_commit && (tr_from == LS_SE0) && (tr_to == LS_J);
  assign remove_evt = tr_commit && (tr_from == LS_J)   && (tr_to == LS_SE0);
  assign resume_evt = tr_commit && (tr_from == LS_J)   && (tr_to == LS_K)
                      && resume_mode;

  always_comb begin
    evt_set = '0;
    evt_set[BIT_DONE_A] = done_a_evt;
    evt_set[BIT_DONE_B] = done_b_evt;
    evt_set[BIT_SOF]    = sof_evt;
    evt_set[BIT_ATTACH] = insert_evt | remove_evt;
    evt_set[BIT_DETRES] = resume_evt;
  end

  assign evt_clr = wr_en ? wr_data : 8'h00;

  usb_irq_bits #(.W(8), .MASK(LATCH_MASK)) u_bits (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (evt_set),
    .clr  (evt_clr),
    .lat  (lat)
  );

  always_comb begin
    rd_data = lat;
    rd_data[BIT_DPLUS]  = dp_sync;
    rd_data[BIT_DETRES] = resume_mode ? lat[BIT_DETRES]
                                      : (line_stable == LS_SE0);
  end

  assign irq = |(lat & live_enables(irq_en, resume_mode));
endmodule

// File: rtl/usb_attach_irq_chk.sv
module usb_attach_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       sof_evt,
  input logic       done_a_evt,
  input logic       resume_mode,
  input logic [7:0] irq_en,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       insert_evt,
  input logic       remove_evt,
  input logic       resume_evt,
  input logic [1:0] line_stable
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:2] == 2'b00);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !done_a_evt) |=> !rd_data[0]);

  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && !(wr_en && wr_data[0])) |=> rd_data[0]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> rd_data[4]);

  p_insert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    insert_evt |=> rd_data[5]);

  p_remove_r6: assert property (@(posedge clk) disable iff (!rst_n)
    remove_evt |=> rd_data[5]);

  p_one_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({insert_evt, remove_evt, resume_evt}));

  p_presence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_mode |-> (rd_data[6] == (line_stable == 2'd0)));

  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_evt |=> (rd_data[6] || !resume_mode));

  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_en & 8'b0111_0011) == 8'h00) |-> !irq);

  p_irq_fire_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] && irq_en[0]) |-> irq);
endmodule

bind usb_attach_irq usb_attach_irq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .sof_evt    (sof_evt),
  .done_a_evt (done_a_evt),
  .resume_mode(resume_mode),
  .irq_en     (irq_en),
  .rd_data    (rd_data),
  .irq        (irq),
  .insert_evt (insert_evt),
  .remove_evt (remove_evt),
  .resume_evt (resume_evt),
  .line_stable(line_stable)
);

// File: tb/usb_attach_irq_test.sv
module usb_attach_irq_test;
  localparam int DEB = 6;
  localparam int SETTLE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dp_in = 1'b0, dm_in = 1'b0;
  logic       low_speed = 1'b0, resume_mode = 1'b0;
  logic [7:0] debounce_cycles = 8'(DEB);
  logic       sof_evt = 1'b0, done_a_evt = 1'b0, done_b_evt = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00, irq_en = 8'h00;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    string      tag;
    bit         is_irq;
    logic [7:0] exp;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  usb_attach_irq uut (
    .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in),
    .low_speed(low_speed), .resume_mode(resume_mode),
    .debounce_cycles(debounce_cycles), .sof_evt(sof_evt),
    .done_a_evt(done_a_evt), .done_b_evt(done_b_evt),
    .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq)
  );

  // monitor: pops expected items and compares shortly after they are queued
  initial begin
    forever begin
      item_t it;
      logic [7:0] act;
      wait (sb.size() != 0);
      #1;
      it = sb.pop_front();
      act = it.is_irq ? {7'd0, irq} : rd_data;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_rd(input string tag, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.is_irq = 1'b0; it.exp = v;
    sb.push_back(it);
    #3;
  endtask

  task automatic exp_irq(input string tag, input logic v);
    item_t it;
    it.tag = tag; it.is_irq = 1'b1; it.exp = {7'd0, v};
    sb.push_back(it);
    #3;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    tick(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic lines(input logic p, input logic m);
    @(negedge clk);
    dp_in = p; dm_in = m;
    tick(SETTLE);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    exp_rd("R1 reset status", 8'h40);
    exp_irq("R1 reset irq", 1'b0);

    // event pulses (R11)
    @(negedge clk); done_a_evt = 1'b1; tick(1); done_a_evt = 1'b0;
    exp_rd("R11 done A", 8'h41);
    @(negedge clk); done_b_evt = 1'b1; tick(1); done_b_evt = 1'b0;
    exp_rd("R11 done B", 8'h43);
    // SOF event together with a clear of the same bit (R4)
    @(negedge clk); sof_evt = 1'b1; wr_en = 1'b1; wr_data = 8'h10;
    tick(1); sof_evt = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    exp_rd("R4 set beats clear", 8'h53);

    // interrupt gating (R12)
    irq_en = 8'h01; #1;
    exp_irq("R12 enabled bit", 1'b1);
    irq_en = 8'hC0; #1;
    exp_irq("R12 dplus and presence never interrupt", 1'b0);
    irq_en = 8'h00;

    // write one to clear (R3) and reserved bits (R2)
    wr(8'h02);
    exp_rd("R3 clear B only", 8'h51);
    wr(8'hFF);
    exp_rd("R3 clear all", 8'h40);
    wr(8'h0C);
    exp_rd("R2 reserved write ignored", 8'h40);

    // glitch shorter than the debounce window (R7)
    @(negedge clk); dp_in = 1'b1; tick(3); dp_in = 1'b0;
    tick(SETTLE);
    exp_rd("R7 glitch ignored", 8'h40);

    // full-speed attach (R5, R10)
    lines(1'b1, 1'b0);
    exp_rd("R5 R10 full-speed attach", 8'hA0);
    irq_en = 8'h20; #1;
    exp_irq("R12 attach irq", 1'b1);
    irq_en = 8'h00;
    wr(8'h20);
    exp_rd("R3 attach cleared", 8'h80);

    // resume in resume mode (R9)
    resume_mode = 1'b1; #1;
    exp_rd("R9 resume bit clear", 8'h80);
    lines(1'b0, 1'b1);
    exp_rd("R9 resume latched", 8'h40);
    irq_en = 8'h40; #1;
    exp_irq("R12 resume irq", 1'b1);
    resume_mode = 1'b0; #1;
    exp_rd("R8 presence on K", 8'h00);
    exp_irq("R12 bit6 gated off", 1'b0);
    resume_mode = 1'b1; irq_en = 8'h00; #1;
    exp_rd("R9 latch retained", 8'h40);
    wr(8'h40);
    exp_rd("R3 resume cleared", 8'h00);
    lines(1'b1, 1'b0);
    exp_rd("R9 K to J no event", 8'h80);

    // detach (R6, R8)
    lines(1'b0, 1'b0);
    exp_rd("R6 detach", 8'h20);
    resume_mode = 1'b0; #1;
    exp_rd("R8 no device", 8'h60);
    wr(8'h20);
    exp_rd("R3 detach cleared", 8'h40);

    // low-speed attach (R5, R10)
    low_speed = 1'b1;
    lines(1'b0, 1'b1);
    exp_rd("R5 R10 low-speed attach", 8'h20);
    // K while not in resume mode latches nothing (R9)
    lines(1'b1, 1'b0);
    exp_rd("R8 R10 K live status", 8'hA0);
    resume_mode = 1'b1; #1;
    exp_rd("R9 no latch outside resume mode", 8'hA0);

    tick(2);
    wait (sb.size() == 0);
    #2;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule